// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches a bank of asynchronous pin inputs and turns their activity into interrupt requests. Each pin is brought into the clock domain through a two-stage synchronizer. It is then tested against a per-pin trigger rule. The rule is either edge or level, and it has a polarity that picks the rising edge or high level, or else the falling edge or low level. Both edge and level hits are captured in a sticky status vector. Capture happens whether or not the pin's interrupt is enabled, so the status alone does not say which pins need service.

Software sees five word-aligned registers through a simple read/write port. Byte offset 0x00 is the status (read-only). Offset 0x04 is the write-one-to-clear port, which reads as zero. Offsets 0x08, 0x0C and 0x10 hold the enable, mode (1 = edge, 0 = level) and polarity (1 = rising/high, 0 = falling/low) bits, with bit n belonging to pin n. A single registered, active-high summary line reports whether any pin is both latched and enabled. Because this output is level-type, it stays high for as long as serviced events remain uncleared, and also when new ones arrive during servicing.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the enable, mode and polarity registers read zero, `irq_out` is 0 and `reg_rdata` is 0.
- R2: A pin's status bit is set by its trigger condition even when the pin's enable bit is 0, and such a pin does not raise `irq_out`.
- R3: In level mode a detection is latched: the status bit stays 1 after the pin level goes away, and it is set again while the level persists, until it is cleared with the level gone.
- R4: Mode bit 1 selects edge detection and 0 selects level detection. Polarity bit 1 selects a rising edge or high level, and 0 selects a falling edge or low level. The opposite transition or level sets nothing.
- R5: A write to offset 0x04 clears each status bit whose data bit is 1. Bits written 0 are unchanged. Reading offset 0x04 returns zero.
- R6: `irq_out` is 1 in the cycle after any bit of (status AND enable) is 1, and 0 in the cycle after none is. It stays 1 while any enabled pending bit remains.
- R7: When a trigger and a clear of the same bit meet in one clock cycle, the bit stays 1.
- R8: Changing a pin's mode or polarity bits does not clear its status. Detection follows the new setting from the next clock.
- R9: A pin change sampled at clock edge k sets status at edge k+2, and `irq_out` for an enabled pin rises at edge k+3.
- R10: A read request sampled at an edge returns the addressed word on `reg_rdata` after that edge. `reg_rdata` is 0 in any cycle that follows no read request.
- R11: Offsets other than the five above, and any address with its two low bits nonzero, read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wen | input | 1 | Write strobe, sampled at the clock edge |
| reg_ren | input | 1 | Read strobe, sampled at the clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered summary interrupt, active high |

## Verification
The hardest case to reach from the ports is a clear that lands in the single cycle in which an edge is being recognised. An edge trigger is high for exactly one clock, two edges after the pin moves. The bench therefore drives the pin on a falling clock edge, counts two rising edges, and places the clear write so that it is sampled on the third. The clear must then lose. Level-mode persistence is reached separately, by clearing while the level is still present and again after it has gone.

// File: rtl/gib_pkg.sv
package gib_pkg;

  // Register word indices (byte offset / 4)
  localparam int WIDX_STATUS = 0;
  localparam int WIDX_CLEAR  = 1;
  localparam int WIDX_ENABLE = 2;
  localparam int WIDX_MODE   = 3;
  localparam int WIDX_POL    = 4;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_CLEAR,
    SEL_ENABLE,
    SEL_MODE,
    SEL_POL,
    SEL_NONE
  } reg_sel_e;

  // Map a byte address to a register; misaligned or unknown -> SEL_NONE
  function automatic reg_sel_e decode_sel(input logic [31:0] byte_addr);
    reg_sel_e sel;
    sel = SEL_NONE;
    if (byte_addr[1:0] == 2'b00) begin
      case (byte_addr[31:2])
        30'(WIDX_STATUS): sel = SEL_STATUS;
        30'(WIDX_CLEAR):  sel = SEL_CLEAR;
        30'(WIDX_ENABLE): sel = SEL_ENABLE;
        30'(WIDX_MODE):   sel = SEL_MODE;
        30'(WIDX_POL):    sel = SEL_POL;
        default:          sel = SEL_NONE;
      endcase
    end
    return sel;
  endfunction

endpackage

// File: rtl/gib_sync.sv
module gib_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[k] <= '0;
          else     chain[k] <= chain[k-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gib_detect.sv
module gib_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] mode_edge,
  input  logic [NUM_PINS-1:0] pol_high,
  output logic [NUM_PINS-1:0] trig
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_sync;
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic rise;
      logic fall;
      assign rise = pin_sync[p] & ~prev_q[p];
      assign fall = ~pin_sync[p] & prev_q[p];

      always_comb begin
        if (mode_edge[p]) trig[p] = pol_high[p] ? rise : fall;
        else              trig[p] = (pin_sync[p] == pol_high[p]);
      end
    end
  endgenerate

endmodule

// File: rtl/gib_status.sv
module gib_status #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] trig,
  input  logic [NUM_PINS-1:0] clr_mask,
  input  logic [NUM_PINS-1:0] enable,
  output logic [NUM_PINS-1:0] status_q,
  output logic                irq_q
);

  // Set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_mask) | trig;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_q & enable);
  end

endmodule

// File: rtl/gib_regfile.sv
module gib_regfile
  import gib_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wen,
  input  logic                reg_ren,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] status_q,
  output logic [NUM_PINS-1:0] enable_q,
  output logic [NUM_PINS-1:0] mode_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic [NUM_PINS-1:0] clr_mask
);

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] wbits;
  logic [NUM_PINS-1:0] rd_vec;
  logic [DATA_W-1:0]   rd_word;

  assign sel   = decode_sel(32'(reg_addr));
  assign wbits = reg_wdata[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      mode_q   <= '0;
      pol_q    <= '0;
    end else if (reg_wen) begin
      case (sel)
        SEL_ENABLE: enable_q <= wbits;
        SEL_MODE:   mode_q   <= wbits;
        SEL_POL:    pol_q    <= wbits;
        default: ;
      endcase
    end
  end

  assign clr_mask = (reg_wen && sel == SEL_CLEAR) ? wbits : '0;

  always_comb begin
    case (sel)
      SEL_STATUS: rd_vec = status_q;
      SEL_ENABLE: rd_vec = enable_q;
      SEL_MODE:   rd_vec = mode_q;
      SEL_POL:    rd_vec = pol_q;
      default:    rd_vec = '0;
    endcase
    rd_word = '0;
    rd_word[NUM_PINS-1:0] = rd_vec;
  end

  always_ff @(posedge clk) begin
    if (rst)          reg_rdata <= '0;
    else if (reg_ren) reg_rdata <= rd_word;
    else              reg_rdata <= '0;
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wen,
  input  logic                reg_ren,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_out
);

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] trig_w;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] enable_q;
  logic [NUM_PINS-1:0] mode_q;
  logic [NUM_PINS-1:0] pol_q;
  logic [NUM_PINS-1:0] clr_mask;

  gib_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gib_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .pin_sync  (pin_sync),
    .mode_edge (mode_q),
    .pol_high  (pol_q),
    .trig      (trig_w)
  );

  gib_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig_w),
    .clr_mask (clr_mask),
    .enable   (enable_q),
    .status_q (status_q),
    .irq_q    (irq_out)
  );

  gib_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_ren   (reg_ren),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .mode_q    (mode_q),
    .pol_q     (pol_q),
    .clr_mask  (clr_mask)
  );

endmodule

// File: rtl/gib_chk.sv
module gib_chk
  import gib_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wen,
  input logic                reg_ren,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] status,
  input logic [NUM_PINS-1:0] enable,
  input logic [NUM_PINS-1:0] trig
);

  logic                armed;
  logic [NUM_PINS-1:0] port_clr;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assign port_clr = (reg_wen && decode_sel(32'(reg_addr)) == SEL_CLEAR)
                    ? reg_wdata[NUM_PINS-1:0] : '0;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq_out == 1'b0 && reg_rdata == '0 && status == '0));

  // R3
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((($past(status) & ~$past(port_clr)) & ~status) == '0));

  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (($past(trig) & ~status) == '0));

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((status & ~$past(status) & ~$past(trig)) == '0));

  // R6
  summary_level_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (irq_out == (|($past(status) & $past(enable)))));

  // R10
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(reg_ren) |-> (reg_rdata == '0));

endmodule

bind gpio_irq_bank gib_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wen   (reg_wen),
  .reg_ren   (reg_ren),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .status    (status_q),
  .enable    (enable_q),
  .trig      (trig_w)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

  localparam logic [4:0] A_STAT = 5'h00;
  localparam logic [4:0] A_CLR  = 5'h04;
  localparam logic [4:0] A_EN   = 5'h08;
  localparam logic [4:0] A_MODE = 5'h0C;
  localparam logic [4:0] A_POL  = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic        reg_ren = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] mode_sh = '0;
  logic [31:0] pol_sh  = '0;

  always #5 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pins),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_ren   (reg_ren),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_ren = 1'b1;
    @(negedge clk);
    reg_ren = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pins[idx] = v;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    settle(1);
    check("R1", "irq_out after reset", {31'd0, irq_out}, 32'd0);
    check("R1", "rdata after reset", reg_rdata, 32'd0);
    rd(A_EN, d);   check("R1", "enable reset", d, 32'd0);
    rd(A_MODE, d); check("R1", "mode reset", d, 32'd0);
    rd(A_POL, d);  check("R1", "polarity reset", d, 32'd0);
    rd(A_CLR, d);  check("R5", "clear reads zero", d, 32'd0);
    // default level-low config with all pins low latches every bit
    rd(A_STAT, d); check("R2", "disabled level-low pins latched", d, 32'hFFFF_FFFF);
    check("R2", "no irq with enables off", {31'd0, irq_out}, 32'd0);
    mode_sh = 32'hFFFF_FFFF; wr(A_MODE, mode_sh);
    pol_sh  = 32'hFFFF_FFFF; wr(A_POL, pol_sh);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STAT, d); check("R5", "clear all", d, 32'd0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_pin(3, 1'b1); set_pin(5, 1'b1);
    settle(5);
    rd(A_STAT, d); check("R4", "rising edges latched", d, 32'h28);
    check("R2", "disabled pins no irq", {31'd0, irq_out}, 32'd0);
    wr(A_CLR, 32'h08);
    rd(A_STAT, d); check("R5", "partial clear keeps zero bits", d, 32'h20);
    wr(A_CLR, 32'h20);
    set_pin(3, 1'b0); set_pin(5, 1'b0);
    settle(5);
    rd(A_STAT, d); check("R4", "falling ignored in rising mode", d, 32'h0);
  endtask

  task automatic t_latency();
    wr(A_EN, 32'h80);
    @(negedge clk); pins[7] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "irq not yet at edge k+2", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R9", "irq at edge k+3", {31'd0, irq_out}, 32'd1);
    wr(A_CLR, 32'h80);
    settle(2);
    check("R6", "irq drops after clear", {31'd0, irq_out}, 32'd0);
    set_pin(7, 1'b0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    set_pin(10, 1'b1);
    settle(4);
    pol_sh[10] = 1'b0; wr(A_POL, pol_sh);
    wr(A_CLR, 32'h400);
    rd(A_STAT, d); check("R5", "pin 10 cleared", d, 32'h0);
    set_pin(10, 1'b0);
    settle(5);
    rd(A_STAT, d); check("R4", "falling edge latched", d, 32'h400);
    wr(A_CLR, 32'h400);
    set_pin(10, 1'b1);
    settle(5);
    rd(A_STAT, d); check("R4", "rising ignored in falling mode", d, 32'h0);
    pol_sh[10] = 1'b1; wr(A_POL, pol_sh);
  endtask

  task automatic t_level();
    logic [31:0] d;
    mode_sh[12] = 1'b0; wr(A_MODE, mode_sh);
    set_pin(12, 1'b1);
    settle(5);
    set_pin(12, 1'b0);
    settle(5);
    rd(A_STAT, d); check("R3", "level hit kept after level gone", d, 32'h1000);
    set_pin(12, 1'b1);
    settle(4);
    wr(A_CLR, 32'h1000);
    rd(A_STAT, d); check("R3", "clear while level present re-latches", d, 32'h1000);
    set_pin(12, 1'b0);
    settle(4);
    wr(A_CLR, 32'h1000);
    rd(A_STAT, d); check("R3", "clear after level gone", d, 32'h0);
    mode_sh[12] = 1'b1; wr(A_MODE, mode_sh);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk); pins[20] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_addr = A_CLR; reg_wdata = 32'h0010_0000; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
    rd(A_STAT, d); check("R7", "trigger beats same-cycle clear", d, 32'h0010_0000);
    wr(A_CLR, 32'h0010_0000);
    rd(A_STAT, d); check("R7", "later clear takes effect", d, 32'h0);
  endtask

  task automatic t_cfg_change();
    logic [31:0] d;
    set_pin(22, 1'b1);
    settle(5);
    mode_sh[22] = 1'b0; wr(A_MODE, mode_sh);
    pol_sh[22]  = 1'b0; wr(A_POL, pol_sh);
    rd(A_STAT, d); check("R8", "config change keeps status", d, 32'h0040_0000);
    wr(A_CLR, 32'h0040_0000);
    rd(A_STAT, d); check("R8", "level-low idle with pin high", d, 32'h0);
    set_pin(22, 1'b0);
    settle(5);
    rd(A_STAT, d); check("R8", "new level-low rule applies", d, 32'h0040_0000);
    mode_sh[22] = 1'b1; wr(A_MODE, mode_sh);
    pol_sh[22]  = 1'b1; wr(A_POL, pol_sh);
    wr(A_CLR, 32'h0040_0000);
    rd(A_STAT, d); check("R8", "restored", d, 32'h0);
  endtask

  task automatic t_irq_hold();
    logic [31:0] d;
    wr(A_EN, 32'h28);
    set_pin(3, 1'b1); set_pin(5, 1'b1);
    settle(5);
    check("R6", "irq with two pending", {31'd0, irq_out}, 32'd1);
    wr(A_CLR, 32'h08);
    settle(2);
    check("R6", "irq held by remaining pin", {31'd0, irq_out}, 32'd1);
    wr(A_CLR, 32'h20);
    settle(2);
    check("R6", "irq low when none pending", {31'd0, irq_out}, 32'd0);
    set_pin(6, 1'b1);
    settle(5);
    check("R2", "disabled pin keeps irq low", {31'd0, irq_out}, 32'd0);
    rd(A_STAT, d); check("R2", "disabled pin latched", d, 32'h40);
    wr(A_CLR, 32'h40);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_access();
    logic [31:0] d;
    wr(A_EN, 32'hA5A5_0000);
    rd(A_EN, d); check("R10", "read returns written word", d, 32'hA5A5_0000);
    @(negedge clk);
    check("R10", "rdata zero when idle", reg_rdata, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, d); check("R11", "unmapped reads zero", d, 32'h0);
    wr(5'h09, 32'hFFFF_FFFF);
    rd(A_EN, d); check("R11", "misaligned write ignored", d, 32'hA5A5_0000);
    rd(5'h0A, d); check("R11", "misaligned read zero", d, 32'h0);
    wr(A_EN, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rise();
    t_latency();
    t_fall();
    t_level();
    t_set_wins();
    t_cfg_change();
    t_irq_hold();
    t_access();
    settle(2);
    finish_run();
  end

endmodule